// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block holds the power-control register of an 8-bit microcontroller core and turns it into clocks. The register sits on the special-function-register bus at address 0x87. It holds a baud-doubling bit, which goes to the serial port, two general-purpose flags, and the two bits that request idle and power-down. From the register state the block produces three outputs: a glitch-free gated CPU clock, an enable for the peripheral clock domain (timers, serial port, interrupt logic), and an enable for the oscillator.

A three-state machine controls the modes.
- `PM_RUN` is the normal state. A write that requests power-down moves it to `PM_DOWN` (transition *sleep*). A write that requests idle only moves it to `PM_IDLE` (transition *doze*).
- In `PM_IDLE`, a pending enabled interrupt returns the machine to `PM_RUN` (transition *wake*).
- `PM_DOWN` leaves only through the asynchronous reset (transition *reset*), which also forces `PM_RUN` from any state.

The CPU clock is gated through a latch. The latch is transparent only while the free-running clock is low, so the write that requests idle completes and no further CPU edge follows it.

Top module: `pcon_ctrl`

## Requirements
- R1: After reset the register reads 0x00, baud_dbl is 0, osc_en and periph_clk_en are 1, and cpu_clk pulses on every clk edge.
- R2: A write or read reaches the register only when sfr_addr is 0x87 and sfr_bit is 0. A bit-level access or another address leaves the register unchanged, and a read that does not hit returns 0x00.
- R3: Bit 7 is the baud-doubling bit and drives baud_dbl. Bits 3 and 2 are general-purpose flags that read back as written. Bits 6 to 4 read 0 and ignore writes.
- R4: A write in `PM_RUN` with bit 0 = 1 and bit 1 = 0 enters `PM_IDLE`. Bit 0 then reads 1, osc_en and periph_clk_en stay 1, and cpu_clk has no rising edge after the clk edge that took the write.
- R5: A write in `PM_RUN` with bit 1 = 1 enters `PM_DOWN` whatever bit 0 holds. Bit 1 then reads 1 and bit 0 reads 0, osc_en and periph_clk_en drop to 0, and cpu_clk stops after the clk edge that took the write.
- R6: In `PM_IDLE`, wake_irq high at a clk edge returns the machine to `PM_RUN`. Bit 0 then reads 0 and the baud and flag bits are kept. cpu_clk stays low at that edge and pulses again from the following edge.
- R7: In `PM_DOWN`, wake_irq has no effect. Only reset leaves the state, and it restores the reset value of R1.
- R8: Writes that arrive in `PM_IDLE` or `PM_DOWN` change no register bit and no mode.
- R9: In `PM_RUN`, wake_irq has no effect on the register or on cpu_clk.
- R10: cpu_clk is never high while clk is low. The gate enable changes only during the low phase of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Special-function-register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_bit | input | 1 | 1 when the access is a bit-level access |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data; 0x00 when the read does not hit |
| wake_irq | input | 1 | An enabled interrupt is pending |
| cpu_clk | output | 1 | Gated CPU clock |
| periph_clk_en | output | 1 | Enable for the timer, serial and interrupt clocks |
| osc_en | output | 1 | Oscillator enable |
| baud_dbl | output | 1 | Baud-doubling select to the serial port |

## Verification
A wrong mode shows at the ports at the first sample after the clk edge that caused it. Bits 1 and 0 of a read, osc_en and periph_clk_en all follow the state register directly. A gating fault shows within one clock as a missing or extra cpu_clk edge, so the bench counts gated edges over a fixed window after each write or wake. A lost flag or baud bit shows on the next read and on baud_dbl.

// File: rtl/pcon_pkg.sv
package pcon_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pmode_e;

    localparam int BIT_IDLE  = 0;
    localparam int BIT_PDOWN = 1;
    localparam int BIT_GF0   = 2;
    localparam int BIT_BAUD  = 7;

endpackage

// File: rtl/pcon_regs.sv
module pcon_regs
    import pcon_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              REG_W    = 8,
    parameter int              NUM_GF   = 2,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              bit_acc,
    input  logic              wd_baud,
    input  logic [NUM_GF-1:0] wd_gf,
    input  pmode_e            mode,
    output logic              wr_take,
    output logic [REG_W-1:0]  rdata,
    output logic              baud_dbl
);

    logic              hit;
    logic              baud_q;
    logic [NUM_GF-1:0] gf_q;

    // byte access at the fixed address only
    assign hit     = (addr == REG_ADDR) && !bit_acc;
    assign wr_take = wr && hit && (mode == PM_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q <= 1'b0;
        end else if (wr_take) begin
            baud_q <= wd_baud;
        end
    end

    for (genvar i = 0; i < NUM_GF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gf_q[i] <= 1'b0;
            end else if (wr_take) begin
                gf_q[i] <= wd_gf[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd && hit) begin
            rdata[BIT_BAUD]                 = baud_q;
            rdata[BIT_GF0 +: NUM_GF]        = gf_q;
            rdata[BIT_PDOWN]                = (mode == PM_DOWN);
            rdata[BIT_IDLE]                 = (mode == PM_IDLE);
        end
    end

    assign baud_dbl = baud_q;

endmodule

// File: rtl/pcon_fsm.sv
module pcon_fsm
    import pcon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_take,
    input  logic   req_pdown,
    input  logic   req_idle,
    input  logic   wake,
    output pmode_e mode,
    output logic   gate_en,
    output logic   periph_en,
    output logic   osc_en
);

    pmode_e mode_q;
    pmode_e mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PM_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

    // next state: power-down has priority over idle
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PM_RUN: begin
                if (wr_take) begin
                    if (req_pdown) begin
                        mode_d = PM_DOWN;
                    end else if (req_idle) begin
                        mode_d = PM_IDLE;
                    end
                end
            end
            PM_IDLE: begin
                if (wake) begin
                    mode_d = PM_RUN;
                end
            end
            PM_DOWN: mode_d = PM_DOWN;
            default: mode_d = PM_RUN;
        endcase
    end

    // outputs
    always_comb begin
        gate_en   = 1'b0;
        periph_en = 1'b0;
        osc_en    = 1'b0;
        unique case (mode_q)
            PM_RUN: begin
                gate_en   = 1'b1;
                periph_en = 1'b1;
                osc_en    = 1'b1;
            end
            PM_IDLE: begin
                periph_en = 1'b1;
                osc_en    = 1'b1;
            end
            PM_DOWN: begin
                gate_en   = 1'b0;
            end
            default: begin
                gate_en   = 1'b1;
                periph_en = 1'b1;
                osc_en    = 1'b1;
            end
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/pcon_clk_gate.sv
module pcon_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk
);

    logic en_l;

    // transparent only in the low phase, so gclk cannot be clipped
    always_latch begin
        if (!rst_n) begin
            en_l = 1'b1;
        end else if (!clk) begin
            en_l = en;
        end
    end

    assign gclk = clk & en_l;

endmodule

// File: rtl/pcon_ctrl.sv
module pcon_ctrl
    import pcon_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              REG_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic              sfr_bit,
    input  logic [REG_W-1:0]  sfr_wdata,
    output logic [REG_W-1:0]  sfr_rdata,
    input  logic              wake_irq,
    output logic              cpu_clk,
    output logic              periph_clk_en,
    output logic              osc_en,
    output logic              baud_dbl
);

    localparam int NUM_GF = BIT_BAUD - BIT_GF0 - 3;

    pmode_e mode;
    logic   wr_take;
    logic   gate_en;

    pcon_regs #(
        .ADDR_W  (ADDR_W),
        .REG_W   (REG_W),
        .NUM_GF  (NUM_GF),
        .REG_ADDR(REG_ADDR)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (sfr_addr),
        .wr      (sfr_wr),
        .rd      (sfr_rd),
        .bit_acc (sfr_bit),
        .wd_baud (sfr_wdata[BIT_BAUD]),
        .wd_gf   (sfr_wdata[BIT_GF0 +: NUM_GF]),
        .mode    (mode),
        .wr_take (wr_take),
        .rdata   (sfr_rdata),
        .baud_dbl(baud_dbl)
    );

    pcon_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_take  (wr_take),
        .req_pdown(sfr_wdata[BIT_PDOWN]),
        .req_idle (sfr_wdata[BIT_IDLE]),
        .wake     (wake_irq),
        .mode     (mode),
        .gate_en  (gate_en),
        .periph_en(periph_clk_en),
        .osc_en   (osc_en)
    );

    pcon_clk_gate gate_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (gate_en),
        .gclk (cpu_clk)
    );

endmodule

// File: rtl/pcon_ctrl_chk.sv
module pcon_ctrl_chk
    import pcon_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input pmode_e     mode,
    input logic       wr_take,
    input logic [1:0] wd_mode,
    input logic       sfr_wr,
    input logic       sfr_bit,
    input logic       wake_irq,
    input logic       cpu_clk,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic       baud_dbl
);

    p_pd_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take && wd_mode[1] |=> mode == PM_DOWN);

    p_pd_clocks_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PM_DOWN |-> !osc_en && !periph_clk_en);

    p_idle_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take && !wd_mode[1] && wd_mode[0] |=> mode == PM_IDLE);

    p_idle_periph_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PM_IDLE |-> osc_en && periph_clk_en);

    p_wake_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PM_IDLE && wake_irq |=> mode == PM_RUN);

    p_pd_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PM_DOWN |=> mode == PM_DOWN);

    p_no_write_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode != PM_RUN |-> !wr_take);

    p_bit_access_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr && sfr_bit |=> $stable(baud_dbl));

    p_run_irq_noeffect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PM_RUN && !wr_take |=> mode == PM_RUN);

    always_comb begin
        if (rst_n && !clk) begin
            p_no_high_when_low_r10: assert (!cpu_clk);
        end
    end

endmodule

bind pcon_ctrl pcon_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .wr_take      (wr_take),
    .wd_mode      (sfr_wdata[1:0]),
    .sfr_wr       (sfr_wr),
    .sfr_bit      (sfr_bit),
    .wake_irq     (wake_irq),
    .cpu_clk      (cpu_clk),
    .periph_clk_en(periph_clk_en),
    .osc_en       (osc_en),
    .baud_dbl     (baud_dbl)
);

// File: tb/pcon_ctrl_tb.sv
module pcon_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic       sfr_rd = 1'b0;
    logic       sfr_bit = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       wake_irq = 1'b0;
    logic       cpu_clk;
    logic       periph_clk_en;
    logic       osc_en;
    logic       baud_dbl;

    int checks = 0;
    int errors = 0;
    int cpu_edges = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge cpu_clk) cpu_edges = cpu_edges + 1;

    pcon_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sfr_addr     (sfr_addr),
        .sfr_wr       (sfr_wr),
        .sfr_rd       (sfr_rd),
        .sfr_bit      (sfr_bit),
        .sfr_wdata    (sfr_wdata),
        .sfr_rdata    (sfr_rdata),
        .wake_irq     (wake_irq),
        .cpu_clk      (cpu_clk),
        .periph_clk_en(periph_clk_en),
        .osc_en       (osc_en),
        .baud_dbl     (baud_dbl)
    );

    // {write data, expected read, expected mode 0 run / 1 idle / 2 down}
    localparam logic [17:0] VEC [0:7] = '{
        {8'h80, 8'h80, 2'd0},
        {8'h0C, 8'h0C, 2'd0},
        {8'h70, 8'h00, 2'd0},
        {8'hFF, 8'h8E, 2'd2},
        {8'h01, 8'h01, 2'd1},
        {8'h03, 8'h02, 2'd2},
        {8'h8D, 8'h8D, 2'd1},
        {8'h84, 8'h84, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic b, input logic [7:0] d);
        @(negedge clk);
        sfr_addr  = a;
        sfr_bit   = b;
        sfr_wdata = d;
        sfr_wr    = 1'b1;
        @(negedge clk);
        sfr_wr    = 1'b0;
        sfr_bit   = 1'b0;
        sfr_wdata = 8'h00;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic b, output logic [7:0] v);
        sfr_addr = a;
        sfr_bit  = b;
        sfr_rd   = 1'b1;
        #1;
        v = sfr_rdata;
        sfr_rd  = 1'b0;
        sfr_bit = 1'b0;
    endtask

    // count gated edges over n negedges; also cpu_clk low while clk low (R10)
    task automatic edges_over(input int n, output int cnt);
        int start;
        start = cpu_edges;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #0.5;
            chk("R10 cpu_clk low in clk low phase", 32'(cpu_clk), 32'd0);
        end
        cnt = cpu_edges - start;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        int         n;
        string      tag;

        // R1: reset state
        do_reset();
        rd_reg(8'h87, 1'b0, v);
        chk("R1 reset read", 32'(v), 32'h00);
        chk("R1 reset osc_en", 32'(osc_en), 32'd1);
        chk("R1 reset periph_clk_en", 32'(periph_clk_en), 32'd1);
        chk("R1 reset baud_dbl", 32'(baud_dbl), 32'd0);
        edges_over(4, n);
        chk("R1 cpu_clk running", 32'(n), 32'd4);

        // table walk: R3 / R4 / R5
        for (int i = 0; i < 8; i++) begin
            logic [7:0] wd;
            logic [7:0] er;
            logic [1:0] em;
            {wd, er, em} = VEC[i];
            tag = (em == 2'd0) ? "R3" : (em == 2'd1) ? "R4" : "R5";
            do_reset();
            wr_reg(8'h87, 1'b0, wd);
            rd_reg(8'h87, 1'b0, v);
            chk({tag, " read"}, 32'(v), 32'(er));
            chk({tag, " osc_en"}, 32'(osc_en), 32'(em != 2'd2));
            chk({tag, " periph_clk_en"}, 32'(periph_clk_en), 32'(em != 2'd2));
            chk({tag, " baud_dbl"}, 32'(baud_dbl), 32'(wd[7]));
            edges_over(4, n);
            chk({tag, " cpu edges after write"}, 32'(n), (em == 2'd0) ? 32'd4 : 32'd0);
        end

        // R2: bit-level write, other address, bit-level read
        do_reset();
        wr_reg(8'h87, 1'b1, 8'h84);
        rd_reg(8'h87, 1'b0, v);
        chk("R2 bit-level write ignored", 32'(v), 32'h00);
        chk("R2 bit-level write baud", 32'(baud_dbl), 32'd0);
        wr_reg(8'h86, 1'b0, 8'h8C);
        rd_reg(8'h87, 1'b0, v);
        chk("R2 other address write ignored", 32'(v), 32'h00);
        wr_reg(8'h87, 1'b0, 8'h08);
        rd_reg(8'h87, 1'b1, v);
        chk("R2 bit-level read returns zero", 32'(v), 32'h00);
        rd_reg(8'h88, 1'b0, v);
        chk("R2 other address read returns zero", 32'(v), 32'h00);
        wr_reg(8'h87, 1'b1, 8'h01);
        edges_over(3, n);
        chk("R2 bit-level idle write ignored", 32'(n), 32'd3);

        // R4 then R6: idle entry and wake
        do_reset();
        wr_reg(8'h87, 1'b0, 8'h8D);
        edges_over(3, n);
        chk("R4 idle holds cpu_clk", 32'(n), 32'd0);
        @(negedge clk);
        wake_irq = 1'b1;
        edges_over(1, n);
        wake_irq = 1'b0;
        chk("R6 no cpu edge at wake edge", 32'(n), 32'd0);
        rd_reg(8'h87, 1'b0, v);
        chk("R6 idle bit cleared, rest kept", 32'(v), 32'h8C);
        edges_over(1, n);
        chk("R6 cpu edge on next clk", 32'(n), 32'd1);
        edges_over(3, n);
        chk("R6 cpu_clk running", 32'(n), 32'd3);

        // R8: write while idle ignored
        do_reset();
        wr_reg(8'h87, 1'b0, 8'h01);
        wr_reg(8'h87, 1'b0, 8'h8A);
        rd_reg(8'h87, 1'b0, v);
        chk("R8 write in idle ignored", 32'(v), 32'h01);
        chk("R8 osc stays on in idle", 32'(osc_en), 32'd1);

        // R7 and R8: power-down ignores wake and writes, reset exits
        do_reset();
        wr_reg(8'h87, 1'b0, 8'h02);
        pulse_wake();
        rd_reg(8'h87, 1'b0, v);
        chk("R7 wake ignored in power-down", 32'(v), 32'h02);
        chk("R7 osc stays off", 32'(osc_en), 32'd0);
        edges_over(3, n);
        chk("R7 cpu_clk stays off", 32'(n), 32'd0);
        wr_reg(8'h87, 1'b0, 8'h80);
        rd_reg(8'h87, 1'b0, v);
        chk("R8 write in power-down ignored", 32'(v), 32'h02);
        do_reset();
        rd_reg(8'h87, 1'b0, v);
        chk("R7 reset exits power-down", 32'(v), 32'h00);
        chk("R7 reset restores osc_en", 32'(osc_en), 32'd1);

        // R9: wake in run has no effect
        do_reset();
        wr_reg(8'h87, 1'b0, 8'h08);
        pulse_wake();
        rd_reg(8'h87, 1'b0, v);
        chk("R9 wake in run keeps register", 32'(v), 32'h08);
        edges_over(4, n);
        chk("R9 wake in run keeps cpu_clk", 32'(n), 32'd4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule